// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the controller side of a two-wire serial bus and frees the bus after a transfer was cut short, after a power loss or after a reset, any of which can leave a target device holding the data line low. When asked, it releases both lines and watches the data line at the end of each clock-high phase. If the data line is low it pulls the clock line low and releases it again, one clock cycle at a time, so that a stuck target can shift out its pending bit and let go.

As soon as the data line reads high at a check, clocking stops. The sequencer then makes a start condition: with the clock line released it pulls the data line low and, after a hold time, pulls the clock line low as well. It flags success and keeps both lines low, ready for a following transfer. If the data line is still low after the last allowed clock cycle, it releases both lines and flags failure. Both lines are driven open-drain: each output only asks for a line to be pulled low. Phase lengths are parameters counted in system clocks.

Top module: `bus_rescue`

## Requirements
- R1: While reset is active and after it with no request, both pull-low enables are 0 (lines released) and both the success and failure flags are 0.
- R2: A recovery releases both lines and checks the data input on the last system clock of each clock-high phase, which lasts T_HIGH cycles; each clock-low phase pulls SCL low for exactly T_LOW cycles.
- R3: A recovery issues at most MAX_PULSES (default 9) clock cycles, a clock cycle being a release of SCL following a low phase in which SDA was not pulled low.
- R4: If the data input is high at the first check, no clock cycle is issued and success is flagged T_HIGH + T_SU_STA + T_HD_STA cycles after the request was sampled.
- R5: If the target frees the data line during clock cycle k (1 <= k <= MAX_PULSES), exactly k clock cycles are issued and success comes T_HIGH + k*(T_LOW+T_HIGH) + T_SU_STA + T_HD_STA cycles after the request.
- R6: The start condition pulls SDA low only while SCL is released and after SCL has been released for at least T_SU_STA cycles; SDA stays low for exactly T_HD_STA cycles before SCL is pulled low.
- R7: Success is a one-cycle pulse on done_o; in that cycle and afterwards both pull-low enables are 1 until the next accepted request.
- R8: If the data input is still low at the check after the last allowed clock cycle, fail_o pulses for one cycle, T_HIGH + MAX_PULSES*(T_LOW+T_HIGH) cycles after the request, with both pull-low enables 0 from then on.
- R9: A request while a recovery is in progress is ignored: the running sequence keeps its timing and no second sequence follows.
- R10: done_o and fail_o are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| recover_i | input | 1 | Start a recovery when idle |
| sda_i | input | 1 | Sampled level of the data line |
| scl_oe_o | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| done_o | output | 1 | One-cycle pulse: start condition made |
| fail_o | output | 1 | One-cycle pulse: line still held after all clock cycles |

## Verification
The bench models a target that holds the data line for a chosen number of clock rises, and goes after the zero-pulse case, a release on exactly the ninth cycle and a release one cycle too late. A design with an off-by-one in the pulse limit would fail on the ninth-cycle case or issue a tenth pulse; one that clocked before checking would show a pulse and a longer latency in the zero case. It also measures the setup and hold of the start condition, where a design that dropped both lines together would show a zero hold, and fires a second request mid-sequence, which a design that restarted would answer with shifted latency or an extra completion.

// File: rtl/bus_rescue_pkg.sv
package bus_rescue_pkg;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_HIGH,
        RS_LOW,
        RS_SETUP,
        RS_HOLD
    } rs_state_e;

    typedef struct packed {
        rs_state_e state;
        logic      park;
        logic      done;
        logic      fail;
    } rs_regs_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bus_rescue_timer.sv
module bus_rescue_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clear_i,
    input  logic [W-1:0] limit_i,
    output logic         last_o
);

    logic [W-1:0] cnt_d, cnt_q;

    assign last_o = (cnt_q == limit_i);

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (clear_i || last_o) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/bus_rescue_pulse_ctr.sv
module bus_rescue_pulse_ctr #(
    parameter int unsigned MAX_PULSES = 9
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic incr_i,
    output logic at_max_o
);

    localparam int unsigned CW = $clog2(MAX_PULSES + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(MAX_PULSES);

    logic [CW-1:0] cnt_d, cnt_q;

    assign at_max_o = (cnt_q == CNT_MAX);

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (incr_i && !at_max_o) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/bus_rescue.sv
module bus_rescue #(
    parameter int unsigned T_HIGH     = 200,
    parameter int unsigned T_LOW      = 235,
    parameter int unsigned T_SU_STA   = 235,
    parameter int unsigned T_HD_STA   = 200,
    parameter int unsigned MAX_PULSES = 9
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic recover_i,
    input  logic sda_i,
    output logic scl_oe_o,
    output logic sda_oe_o,
    output logic done_o,
    output logic fail_o
);
    import bus_rescue_pkg::*;

    localparam int unsigned TMAX = max2(max2(T_HIGH, T_LOW), max2(T_SU_STA, T_HD_STA));
    localparam int unsigned TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] LIM_HIGH  = TW'(T_HIGH - 1);
    localparam logic [TW-1:0] LIM_LOW   = TW'(T_LOW - 1);
    localparam logic [TW-1:0] LIM_SETUP = TW'(T_SU_STA - 1);
    localparam logic [TW-1:0] LIM_HOLD  = TW'(T_HD_STA - 1);

    rs_regs_t      r_d, r_q;
    logic          tmr_clear, tmr_last;
    logic [TW-1:0] tmr_limit;
    logic          pc_clear, pc_incr, pc_at_max;

    bus_rescue_timer #(.W(TW)) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (tmr_clear),
        .limit_i (tmr_limit),
        .last_o  (tmr_last)
    );

    bus_rescue_pulse_ctr #(.MAX_PULSES(MAX_PULSES)) u_pulses (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (pc_clear),
        .incr_i   (pc_incr),
        .at_max_o (pc_at_max)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.fail  = 1'b0;
        tmr_clear = 1'b0;
        tmr_limit = LIM_HIGH;
        pc_clear  = 1'b0;
        pc_incr   = 1'b0;
        unique case (r_q.state)
            RS_IDLE: begin
                tmr_clear = 1'b1;
                pc_clear  = 1'b1;
                if (recover_i) begin
                    r_d.state = RS_HIGH;
                    r_d.park  = 1'b0;
                end
            end
            RS_HIGH: begin
                tmr_limit = LIM_HIGH;
                if (tmr_last) begin
                    if (sda_i) begin
                        r_d.state = RS_SETUP;
                    end else if (pc_at_max) begin
                        r_d.state = RS_IDLE;
                        r_d.fail  = 1'b1;
                    end else begin
                        r_d.state = RS_LOW;
                        pc_incr   = 1'b1;
                    end
                end
            end
            RS_LOW: begin
                tmr_limit = LIM_LOW;
                if (tmr_last) begin
                    r_d.state = RS_HIGH;
                end
            end
            RS_SETUP: begin
                tmr_limit = LIM_SETUP;
                if (tmr_last) begin
                    r_d.state = RS_HOLD;
                end
            end
            RS_HOLD: begin
                tmr_limit = LIM_HOLD;
                if (tmr_last) begin
                    r_d.state = RS_IDLE;
                    r_d.park  = 1'b1;
                    r_d.done  = 1'b1;
                end
            end
            default: begin
                r_d.state = RS_IDLE;
                r_d.park  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{state: RS_IDLE, park: 1'b0, done: 1'b0, fail: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_oe_o = (r_q.state == RS_LOW) || ((r_q.state == RS_IDLE) && r_q.park);
    assign sda_oe_o = (r_q.state == RS_HOLD) || ((r_q.state == RS_IDLE) && r_q.park);
    assign done_o   = r_q.done;
    assign fail_o   = r_q.fail;

endmodule

// File: rtl/bus_rescue_chk.sv
module bus_rescue_chk #(
    parameter int unsigned MAX_PULSES = 9
) (
    input logic clk_i,
    input logic rst_ni,
    input logic scl_oe_o,
    input logic sda_oe_o,
    input logic done_o,
    input logic fail_o
);

    logic scl_prev, sda_prev;
    int unsigned pulse_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            scl_prev  <= 1'b0;
            sda_prev  <= 1'b0;
            pulse_cnt <= 0;
        end else begin
            scl_prev <= scl_oe_o;
            sda_prev <= sda_oe_o;
            if (done_o || fail_o) begin
                pulse_cnt <= 0;
            end else if (scl_prev && !scl_oe_o && !sda_prev) begin
                pulse_cnt <= pulse_cnt + 1;
            end
        end
    end

    // R3: clock cycles within one recovery never exceed the limit
    a_r3_pulse_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_cnt <= MAX_PULSES);

    // R6: SDA is pulled low only while SCL is released
    a_r6_start_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sda_oe_o) |-> !scl_oe_o);

    // R6: when SCL is pulled low with SDA low, SDA was already low before
    a_r6_hold_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(scl_oe_o) && sda_oe_o) |-> $past(sda_oe_o));

    // R7: success leaves both lines pulled low
    a_r7_done_parks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (scl_oe_o && sda_oe_o));

    // R7: success flag lasts one cycle
    a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R8: failure releases both lines
    a_r8_fail_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail_o |-> (!scl_oe_o && !sda_oe_o));

    // R8: failure flag lasts one cycle
    a_r8_fail_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail_o |=> !fail_o);

    // R10: flags are exclusive
    a_r10_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(done_o && fail_o));

endmodule

bind bus_rescue bus_rescue_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scl_oe_o (scl_oe_o),
    .sda_oe_o (sda_oe_o),
    .done_o   (done_o),
    .fail_o   (fail_o)
);

// File: tb/bus_rescue_test.sv
module bus_rescue_test;

    localparam int CLK_PERIOD = 10;
    localparam int TH   = 4;
    localparam int TL   = 5;
    localparam int TSU  = 6;
    localparam int THD  = 3;
    localparam int MAXP = 9;

    typedef struct {
        bit    is_fail;
        int    pulses;
        int    latency;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic recover = 1'b0;
    logic scl_oe, sda_oe, done, fail;
    logic sda_in;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int rises = 0;
    int base = 0;
    int target = 0;
    int start_cyc = 0;
    int issued = 0;
    int seen = 0;
    exp_t exp_q[$];

    bit scl_prev_p = 1'b1;
    bit sda_oe_prev_p = 1'b0;
    bit scl_line, sda_line, slave_low;

    bus_rescue #(
        .T_HIGH(TH), .T_LOW(TL), .T_SU_STA(TSU), .T_HD_STA(THD), .MAX_PULSES(MAXP)
    ) uut (
        .clk_i(clk), .rst_ni(rst_n), .recover_i(recover), .sda_i(sda_in),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .done_o(done), .fail_o(fail)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    assign slave_low = ((rises - base) < target);
    assign scl_line  = !scl_oe;
    assign sda_line  = !sda_oe && !slave_low;
    assign sda_in    = sda_line;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // system clock count and target-side clock rise counter
    always @(posedge clk) begin
        cyc <= cyc + 1;
        scl_prev_p    <= scl_line;
        sda_oe_prev_p <= sda_oe;
        if (rst_n && scl_line && !scl_prev_p && !sda_oe_prev_p) begin
            rises <= rises + 1;
        end
    end

    // line timing trackers
    int hi_cnt = 0, lo_cnt = 0, last_lo = 0, su_meas = 0, hd_meas = -1, sda_fall_cyc = 0;
    bit scl_prev_n = 1'b1, sda_prev_n = 1'b1;
    bit pulse_chk = 1'b0;

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_line && !scl_prev_n) last_lo = lo_cnt;
            if (!scl_line && scl_prev_n && !sda_line) hd_meas = cyc - sda_fall_cyc;
            if (!sda_line && sda_prev_n && scl_line) begin
                su_meas = hi_cnt;
                sda_fall_cyc = cyc;
            end
            if (scl_line) begin hi_cnt++; lo_cnt = 0; end
            else begin lo_cnt++; hi_cnt = 0; end
            scl_prev_n = scl_line;
            sda_prev_n = sda_line;

            if (pulse_chk) begin
                chk(!done && !fail, "R7", "flag longer than one cycle", int'(done) + int'(fail), 0);
                pulse_chk = 1'b0;
            end
            if (done || fail) begin
                pulse_chk = 1'b1;
                chk(!(done && fail), "R10", "done and fail together", 1, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected completion", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(fail == e.is_fail, e.req, "completion kind (fail)", int'(fail), int'(e.is_fail));
                    chk((rises - base) == e.pulses, "R3", "clock cycles issued", rises - base, e.pulses);
                    chk((cyc - start_cyc) == e.latency, e.req, "latency", cyc - start_cyc, e.latency);
                    if (!e.is_fail) begin
                        chk(su_meas >= TSU, "R6", "start setup cycles", su_meas, TSU);
                        chk(hd_meas == THD, "R6", "start hold cycles", hd_meas, THD);
                        if (e.pulses > 0)
                            chk(last_lo == TL, "R2", "clock low phase", last_lo, TL);
                    end
                    seen++;
                end
            end
        end
    end

    // watchdog
    always @(negedge clk) begin
        if (cyc > 100000) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic run_seq(input int tgt, input string req, input bit poke_busy);
        exp_t e;
        if (tgt <= MAXP) begin
            e.is_fail = 1'b0;
            e.pulses  = tgt;
            e.latency = TH + tgt*(TL+TH) + TSU + THD;
        end else begin
            e.is_fail = 1'b1;
            e.pulses  = MAXP;
            e.latency = TH + MAXP*(TL+TH);
        end
        e.req = req;
        @(negedge clk);
        base   = rises;
        target = tgt;
        exp_q.push_back(e);
        issued++;
        recover = 1'b1;
        @(negedge clk);
        recover = 1'b0;
        start_cyc = cyc;
        if (poke_busy) begin
            repeat (7) @(negedge clk);
            recover = 1'b1;
            @(negedge clk);
            recover = 1'b0;
        end
        while (seen < issued) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!scl_oe && !sda_oe, "R1", "lines in reset", int'(scl_oe) + int'(sda_oe), 0);
        chk(!done && !fail, "R1", "flags in reset", int'(done) + int'(fail), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!scl_oe && !sda_oe && !done && !fail, "R1", "idle after reset",
            int'(scl_oe) + int'(sda_oe) + int'(done) + int'(fail), 0);

        run_seq(0, "R4", 1'b0);
        repeat (3) @(negedge clk);
        chk(scl_oe && sda_oe, "R7", "lines parked low after success", int'(scl_oe) + int'(sda_oe), 2);

        run_seq(3, "R5", 1'b0);
        run_seq(1, "R5", 1'b0);
        run_seq(MAXP, "R5", 1'b0);

        run_seq(MAXP + 1, "R8", 1'b0);
        @(negedge clk);
        chk(!scl_oe && !sda_oe, "R8", "lines released after fail", int'(scl_oe) + int'(sda_oe), 0);

        run_seq(25, "R8", 1'b0);

        run_seq(2, "R9", 1'b1);
        repeat (40) @(negedge clk);
        chk(scl_oe && sda_oe, "R9", "no second sequence after busy request",
            int'(scl_oe) + int'(sda_oe), 2);
        chk(exp_q.size() == 0 && seen == issued, "R9", "completions match requests", seen, issued);

        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule